// File: doc/BRIEF.md
# Serial Transmitter with Commanded Break

This block is the transmit half of one asynchronous serial channel. A byte written by the host goes into a one-entry holding register. From there it moves into a shift register and leaves on the serial line as a frame: a low start bit, eight data bits with the least significant bit first, and a high stop bit. The line idles high. A transmit clock enable paces the bit timing. Each bit lasts sixteen enable pulses, unless the clock select input holds the code `1111`, in which case each bit lasts one pulse.

The host controls the channel through a command word. Its two low bits enable or disable the transmitter. Its four high bits carry one operation at a time:
- start a break (hold the line low);
- end the break;
- drive RTS low or high;
- return the transmitter to its reset state.

A break is ordered against the data: it starts only after every character already queued, or queued later, has left the line. Disabling the transmitter does not cut a frame off. Characters already accepted still go out, and only then does the line rest.

The sequencer has six named states:
- `ST_IDLE`: line high.
- `ST_START`: start bit.
- `ST_DATA`: eight data bits.
- `ST_STOP`: stop bit.
- `ST_BREAK`: line held low.
- `ST_MARK`: one high bit after a break.

All transitions happen on a bit boundary:
- Load: from `ST_IDLE`, `ST_STOP` or `ST_MARK` to `ST_START` when the holding register is full.
- Shift: from `ST_START` to `ST_DATA`, then after eight bits to `ST_STOP`.
- Break entry: from `ST_IDLE` or `ST_STOP` to `ST_BREAK` when a break is requested and nothing is queued.
- Break exit: from `ST_BREAK` to `ST_MARK` once the request is withdrawn.
- Rest: from `ST_STOP` or `ST_MARK` to `ST_IDLE` when nothing is waiting.
- Reset: the transmitter-reset operation forces `ST_IDLE` from any state.

Top module: `sertx_break_ctl`

## Requirements
- R1: After reset, `txd` and `rts_n` are high, `tx_rdy` and `tx_emt` are low, and the transmitter is disabled.
- R2: A frame is one low start bit, then 8 data bits LSB first, then one high stop bit. A bit lasts 16 pulses of `bit_clk_en`, or 1 pulse when `clk_sel` is `4'hF`.
- R3: Command bit 0 (enable) makes `tx_rdy` high while the holding register is empty. `tx_emt` is high only when the transmitter is enabled, the holding register is empty and no bit is being sent; the line is then high.
- R4: A write (`wr_en`) while `tx_rdy` is low is ignored: the byte already held is sent unchanged and no extra frame appears.
- R5: Command bit 1 (disable) drops `tx_rdy` and `tx_emt` on the next clock. Characters already in the holding or shift register are still sent completely. Writes made while disabled are ignored.
- R6: Operation `4'h6` in `cmd[5:2]` (start break) is accepted only if the transmitter is already enabled. With nothing queued, the line goes low within two bit times.
- R7: A break begins only after the character being shifted, the one held, and any written after the start-break command have all been sent with their stop bits.
- R8: Operation `4'h7` (stop break) returns the line high within two bit times. A character queued during the break starts after exactly one high bit time.
- R9: Operation `4'h8` drives `rts_n` low on the next clock, and operation `4'h9` drives it high.
- R10: Operation `4'h3` returns the transmitter to its reset state on the next clock: line high, disabled, both registers emptied, break cancelled. `rts_n` keeps its value.
- R11: If bits 0 and 1 are both set in one command word, disable wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_clk_en | input | 1 | Transmit clock enable (16X or 1X pulses) |
| clk_sel | input | 4 | Transmit clock select; `4'hF` selects 1X, any other code selects 16X |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | DATA_W (8) | Byte to transmit |
| cmd_en | input | 1 | Command write strobe |
| cmd | input | 6 | [5:2] operation, [1] disable, [0] enable |
| txd | output | 1 | Serial line |
| rts_n | output | 1 | Request-to-send, active low |
| tx_rdy | output | 1 | Holding register can take a byte |
| tx_emt | output | 1 | Holding register, shift register and line all idle |

## Verification
The basic frame is driven with bytes of alternating, single-bit, all-zero and all-one patterns, in both 1X and 16X timing. These patterns expose a reversed bit order, a dropped or doubled bit, and a wrong bit length. Back-to-back writes, one of them rejected, separate a holding register that protects its contents from one that gets overwritten.

The break tests cover three situations: requesting a break on an empty transmitter, requesting it behind three queued characters, and queuing a character during the break. Together they distinguish a break that cuts into data from one ordered correctly, and measure the single high bit before the next frame. Disabling with two characters pending, and resetting in the middle of a frame, show whether draining and the reset state behave as required.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_BREAK,
        ST_MARK
    } tx_state_e;

    localparam logic [3:0] OP_RST_TX  = 4'h3;
    localparam logic [3:0] OP_BRK_ON  = 4'h6;
    localparam logic [3:0] OP_BRK_OFF = 4'h7;
    localparam logic [3:0] OP_RTS_ON  = 4'h8;
    localparam logic [3:0] OP_RTS_OFF = 4'h9;

    localparam logic [3:0] SEL_1X = 4'hF;

endpackage

// File: rtl/sertx_bit_timer.sv
module sertx_bit_timer #(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    input  logic one_x,
    output logic bit_tick
);

    localparam int CW = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap     = one_x || (cnt == LAST);
    assign bit_tick = tick && wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= wrap ? '0 : cnt + 1'b1;
        end
    end

    // R2: a bit boundary never occurs without a clock enable pulse
    a_r2_tick_gated: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> tick);

endmodule

// File: rtl/sertx_hold_reg.sv
module sertx_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic              take,
    input  logic [DATA_W-1:0] din,
    output logic              full,
    output logic [DATA_W-1:0] dout
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            dout <= '0;
        end else if (clear) begin
            full <= 1'b0;
        end else if (load) begin
            full <= 1'b1;
            dout <= din;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    // R4: a held byte is neither lost nor overwritten until it is taken
    a_r4_keep_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !take && !clear) |=> (full && $stable(dout)));

endmodule

// File: rtl/sertx_cmd_ctl.sv
module sertx_cmd_ctl
    import sertx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_en,
    input  logic [5:0] cmd,
    output logic       tx_en,
    output logic       brk_want,
    output logic       rts_n,
    output logic       xmt_clear
);

    logic [3:0] op;
    logic       dis_bit;
    logic       ena_bit;

    assign op      = cmd[5:2];
    assign dis_bit = cmd[1];
    assign ena_bit = cmd[0];

    assign xmt_clear = cmd_en && (op == OP_RST_TX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_en    <= 1'b0;
            brk_want <= 1'b0;
            rts_n    <= 1'b1;
        end else if (xmt_clear) begin
            tx_en    <= 1'b0;
            brk_want <= 1'b0;
        end else if (cmd_en) begin
            if (dis_bit) begin
                tx_en <= 1'b0;
            end else if (ena_bit) begin
                tx_en <= 1'b1;
            end
            case (op)
                OP_BRK_ON:  if (tx_en) brk_want <= 1'b1;
                OP_BRK_OFF: brk_want <= 1'b0;
                OP_RTS_ON:  rts_n    <= 1'b0;
                OP_RTS_OFF: rts_n    <= 1'b1;
                default:    ;
            endcase
        end
    end

    // R6: a break request only appears while the transmitter was enabled
    a_r6_brk_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_want) |-> $past(tx_en));

    // R9: RTS follows its two operations on the next clock
    a_r9_rts_low: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_en && op == OP_RTS_ON) |=> !rts_n);
    a_r9_rts_high: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_en && op == OP_RTS_OFF) |=> rts_n);

    // R10: the reset operation leaves RTS untouched
    a_r10_rts_kept: assert property (@(posedge clk) disable iff (!rst_n)
        xmt_clear |=> $stable(rts_n));

endmodule

// File: rtl/sertx_frame_fsm.sv
module sertx_frame_fsm
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              bit_tick,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              brk_want,
    output logic              take,
    output logic              txd,
    output logic              idle
);

    localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

    tx_state_e         state;
    tx_state_e         nxt;
    logic [DATA_W-1:0] shreg;
    logic [BW-1:0]     bitcnt;
    logic              in_brk;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else if (clear) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next state and load strobe
    always_comb begin
        nxt  = state;
        take = 1'b0;
        if (bit_tick) begin
            unique case (state)
                ST_IDLE: begin
                    if (hold_full) begin
                        nxt  = ST_START;
                        take = 1'b1;
                    end else if (brk_want) begin
                        nxt = ST_BREAK;
                    end
                end
                ST_START: nxt = ST_DATA;
                ST_DATA: begin
                    if (bitcnt == LAST_BIT) nxt = ST_STOP;
                end
                ST_STOP: begin
                    if (hold_full) begin
                        nxt  = ST_START;
                        take = 1'b1;
                    end else if (brk_want) begin
                        nxt = ST_BREAK;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
                ST_BREAK: begin
                    if (!brk_want) nxt = ST_MARK;
                end
                ST_MARK: begin
                    if (hold_full) begin
                        nxt  = ST_START;
                        take = 1'b1;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= '0;
            bitcnt <= '0;
        end else if (clear) begin
            shreg  <= '0;
            bitcnt <= '0;
        end else if (take) begin
            shreg  <= hold_data;
            bitcnt <= '0;
        end else if (bit_tick && state == ST_DATA) begin
            shreg  <= shreg >> 1;
            bitcnt <= bitcnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_START, ST_BREAK: txd = 1'b0;
            ST_DATA:            txd = shreg[0];
            default:            txd = 1'b1;
        endcase
        idle   = (state == ST_IDLE);
        in_brk = (state == ST_BREAK);
    end

    // R7: a break starts only when nothing was waiting in the holding register
    a_r7_break_after_queue: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_brk) |-> !$past(hold_full));

    // R8: leaving a break always passes through a high mark bit
    a_r8_mark_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (in_brk && bit_tick && !brk_want && !clear) |=> (state == ST_MARK && txd));

    // R2: the last data bit is followed by a high stop bit
    a_r2_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && bit_tick && bitcnt == LAST_BIT && !clear) |=> txd);

    // R2: a loaded frame opens with a low start bit
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !clear) |=> !txd);

endmodule

// File: rtl/sertx_break_ctl.sv
module sertx_break_ctl
    import sertx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_clk_en,
    input  logic [3:0]        clk_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cmd_en,
    input  logic [5:0]        cmd,
    output logic              txd,
    output logic              rts_n,
    output logic              tx_rdy,
    output logic              tx_emt
);

    logic              tx_en;
    logic              brk_want;
    logic              xmt_clear;
    logic              bit_tick;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              take;
    logic              fsm_idle;
    logic              load;
    logic              one_x;

    assign one_x  = (clk_sel == SEL_1X);
    assign tx_rdy = tx_en && !hold_full;
    assign tx_emt = tx_rdy && fsm_idle;
    assign load   = wr_en && tx_rdy;

    sertx_cmd_ctl u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_en    (cmd_en),
        .cmd       (cmd),
        .tx_en     (tx_en),
        .brk_want  (brk_want),
        .rts_n     (rts_n),
        .xmt_clear (xmt_clear)
    );

    sertx_bit_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (xmt_clear),
        .tick     (bit_clk_en),
        .one_x    (one_x),
        .bit_tick (bit_tick)
    );

    sertx_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (xmt_clear),
        .load  (load),
        .take  (take),
        .din   (wr_data),
        .full  (hold_full),
        .dout  (hold_data)
    );

    sertx_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (xmt_clear),
        .bit_tick  (bit_tick),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .brk_want  (brk_want),
        .take      (take),
        .txd       (txd),
        .idle      (fsm_idle)
    );

    // R3: an empty transmitter always rests the line high
    a_r3_emt_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        tx_emt |-> txd);

    // R5 and R11: a disable bit clears both status flags on the next clock
    a_r5_disable_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_en && cmd[1]) |=> (!tx_rdy && !tx_emt));

    // R10: the reset operation empties and disables the transmitter
    a_r10_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        xmt_clear |=> (!tx_rdy && txd && !hold_full));

endmodule

// File: tb/sertx_break_ctl_test.sv
`timescale 1ns/1ps
module sertx_break_ctl_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bit_clk_en;
    logic [3:0] clk_sel;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       cmd_en;
    logic [5:0] cmd;
    logic       txd;
    logic       rts_n;
    logic       tx_rdy;
    logic       tx_emt;

    int n_chk  = 0;
    int n_fail = 0;

    logic       rx_on = 1'b0;
    logic       rx16  = 1'b0;
    logic [7:0] rx_buf [0:31];
    int         rx_cnt  = 0;
    int         rx_ferr = 0;

    localparam logic [5:0] C_EN     = 6'b0000_01;
    localparam logic [5:0] C_DIS    = 6'b0000_10;
    localparam logic [5:0] C_BOTH   = 6'b0000_11;
    localparam logic [5:0] C_BRK_ON = {4'h6, 2'b00};
    localparam logic [5:0] C_BRK_OF = {4'h7, 2'b00};
    localparam logic [5:0] C_RTS_ON = {4'h8, 2'b00};
    localparam logic [5:0] C_RTS_OF = {4'h9, 2'b00};
    localparam logic [5:0] C_RST    = {4'h3, 2'b00};

    // {16X mode, byte sent, byte expected}
    localparam int NVEC = 8;
    localparam logic [16:0] VEC [0:NVEC-1] = '{
        {1'b0, 8'h55, 8'h55},
        {1'b0, 8'h01, 8'h01},
        {1'b0, 8'h80, 8'h80},
        {1'b0, 8'hFF, 8'hFF},
        {1'b1, 8'h00, 8'h00},
        {1'b1, 8'hA5, 8'hA5},
        {1'b1, 8'h3C, 8'h3C},
        {1'b1, 8'hFE, 8'hFE}
    };

    sertx_break_ctl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_clk_en (bit_clk_en),
        .clk_sel    (clk_sel),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .cmd_en     (cmd_en),
        .cmd        (cmd),
        .txd        (txd),
        .rts_n      (rts_n),
        .tx_rdy     (tx_rdy),
        .tx_emt     (tx_emt)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic cmd_w(input logic [5:0] c);
        @(negedge clk);
        cmd_en = 1'b1;
        cmd    = c;
        @(negedge clk);
        cmd_en = 1'b0;
        cmd    = '0;
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_rdy();
        while (tx_rdy !== 1'b1) @(negedge clk);
    endtask

    task automatic wait_rx(input int target);
        while (rx_cnt < target) @(negedge clk);
    endtask

    task automatic set_mode(input logic m16);
        rx16    = m16;
        clk_sel = m16 ? 4'h0 : 4'hF;
    endtask

    // independent frame decoder
    initial begin
        logic [7:0] b;
        int half;
        int bt;
        forever begin
            @(negedge clk);
            if (rx_on && txd === 1'b0) begin
                half = rx16 ? 8 : 0;
                bt   = rx16 ? 16 : 1;
                repeat (half) @(negedge clk);
                for (int i = 0; i < 8; i++) begin
                    repeat (bt) @(negedge clk);
                    b[i] = txd;
                end
                repeat (bt) @(negedge clk);
                if (txd !== 1'b1) rx_ferr++;
                rx_buf[rx_cnt[4:0]] = b;
                rx_cnt++;
            end
        end
    end

    // watchdog
    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL R1-watchdog: run actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int base;
        int n;
        int lows;
        rst_n      = 1'b0;
        bit_clk_en = 1'b1;
        wr_en      = 1'b0;
        wr_data    = '0;
        cmd_en     = 1'b0;
        cmd        = '0;
        set_mode(1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1", "txd", int'(txd), 1);
        chk("R1", "rts_n", int'(rts_n), 1);
        chk("R1", "tx_rdy", int'(tx_rdy), 0);
        chk("R1", "tx_emt", int'(tx_emt), 0);

        // R5: write before enable ignored
        rx_on = 1'b1;
        wr(8'hA5);
        repeat (30) @(negedge clk);
        chk("R5", "frames while disabled", rx_cnt, 0);

        // R3: enable
        cmd_w(C_EN);
        chk("R3", "tx_rdy after enable", int'(tx_rdy), 1);
        chk("R3", "tx_emt after enable", int'(tx_emt), 1);

        // R2: table of frames
        for (int v = 0; v < NVEC; v++) begin
            set_mode(VEC[v][16]);
            base = rx_cnt;
            wait_rdy();
            wr(VEC[v][15:8]);
            chk("R3", "tx_emt while busy", int'(tx_emt), 0);
            wait_rx(base + 1);
            chk("R2", "frame byte", int'(rx_buf[base[4:0]]), int'(VEC[v][7:0]));
            repeat (20) @(negedge clk);
            chk("R3", "tx_emt after frame", int'(tx_emt), 1);
        end
        chk("R2", "stop bit errors", rx_ferr, 0);

        // R4: write while holding register full is ignored
        set_mode(1'b1);
        base = rx_cnt;
        wr(8'h11);
        wait_rdy();
        wr(8'h22);
        chk("R4", "tx_rdy with byte held", int'(tx_rdy), 0);
        wr(8'h33);
        wait_rx(base + 2);
        repeat (400) @(negedge clk);
        chk("R4", "frame count", rx_cnt - base, 2);
        chk("R4", "first byte", int'(rx_buf[base[4:0]]), 8'h11);
        chk("R4", "second byte", int'(rx_buf[(base + 1) % 32]), 8'h22);

        // R11: enable and disable together
        cmd_w(C_BOTH);
        chk("R11", "tx_rdy after both bits", int'(tx_rdy), 0);
        cmd_w(C_EN);

        // R5: disable drains pending characters
        base = rx_cnt;
        wr(8'h3C);
        wait_rdy();
        wr(8'hC3);
        cmd_w(C_DIS);
        chk("R5", "tx_rdy after disable", int'(tx_rdy), 0);
        chk("R5", "tx_emt after disable", int'(tx_emt), 0);
        wait_rx(base + 2);
        chk("R5", "drained first", int'(rx_buf[base[4:0]]), 8'h3C);
        chk("R5", "drained second", int'(rx_buf[(base + 1) % 32]), 8'hC3);
        repeat (100) @(negedge clk);
        chk("R5", "line idle after drain", int'(txd), 1);
        wr(8'h77);
        repeat (400) @(negedge clk);
        chk("R5", "write while disabled", rx_cnt - base, 2);

        // R6: break ignored while disabled
        rx_on = 1'b0;
        cmd_w(C_BRK_ON);
        lows = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (txd === 1'b0) lows++;
        end
        chk("R6", "low samples when disabled", lows, 0);

        // R6: break from empty transmitter
        cmd_w(C_EN);
        cmd_w(C_BRK_ON);
        n = 0;
        while (txd !== 1'b0 && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk("R6", "break within two bits", int'(n <= 32), 1);
        lows = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (txd === 1'b0) lows++;
        end
        chk("R6", "break held low", lows, 100);

        // R8: stop break, one mark bit, then queued character
        base = rx_cnt;
        wait_rdy();
        wr(8'h5A);
        cmd_w(C_BRK_OF);
        n = 0;
        while (txd !== 1'b1 && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk("R8", "line high within two bits", int'(n <= 32), 1);
        rx_on = 1'b1;
        n = 0;
        while (txd === 1'b1 && n < 60) begin
            @(negedge clk);
            n++;
        end
        chk("R8", "mark length in cycles", n, 16);
        wait_rx(base + 1);
        chk("R8", "byte after break", int'(rx_buf[base[4:0]]), 8'h5A);

        // R7: break waits for queued characters
        repeat (40) @(negedge clk);
        base = rx_cnt;
        wr(8'h81);
        wait_rdy();
        wr(8'h42);
        cmd_w(C_BRK_ON);
        wait_rdy();
        wr(8'hE7);
        wait_rx(base + 3);
        rx_on = 1'b0;
        chk("R7", "queued 1", int'(rx_buf[base[4:0]]), 8'h81);
        chk("R7", "queued 2", int'(rx_buf[(base + 1) % 32]), 8'h42);
        chk("R7", "late queued 3", int'(rx_buf[(base + 2) % 32]), 8'hE7);
        chk("R7", "stop bits before break", rx_ferr, 0);
        n = 0;
        while (txd !== 1'b0 && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk("R7", "break after last stop", int'(n <= 16), 1);
        cmd_w(C_BRK_OF);
        repeat (40) @(negedge clk);
        chk("R8", "line high after stop break", int'(txd), 1);

        // R9: RTS control
        cmd_w(C_RTS_ON);
        chk("R9", "rts_n after assert", int'(rts_n), 0);
        cmd_w(C_RTS_OF);
        chk("R9", "rts_n after negate", int'(rts_n), 1);
        cmd_w(C_RTS_ON);

        // R10: transmitter reset mid-frame
        wr(8'h00);
        wr(8'h0F);
        repeat (40) @(negedge clk);
        cmd_w(C_RST);
        chk("R10", "txd after reset op", int'(txd), 1);
        chk("R10", "tx_rdy after reset op", int'(tx_rdy), 0);
        chk("R10", "rts_n kept", int'(rts_n), 0);
        lows = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (txd === 1'b0) lows++;
        end
        chk("R10", "no frame resumes", lows, 0);
        cmd_w(C_EN);
        chk("R10", "holding emptied", int'(tx_emt), 1);

        // R10: reset cancels break
        cmd_w(C_BRK_ON);
        repeat (40) @(negedge clk);
        chk("R6", "break active before reset", int'(txd), 0);
        cmd_w(C_RST);
        cmd_w(C_EN);
        repeat (60) @(negedge clk);
        chk("R10", "break cancelled", int'(txd), 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule